// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit with Master Override

This block is the output-compare half of a general-purpose timer. A free-running 16-bit counter is compared, every clock, against eight 16-bit compare registers. Each channel is configured either as a plain port pin or as an output compare. An output-compare channel carries a two-bit pin action that is applied to its own port bit when its compare matches: leave it, toggle it, clear it or set it. The results land in a registered port latch. That latch drives the eight timer pins whenever a channel is set up to drive its pin.

The highest channel is the master. When it matches, it copies a data byte onto every port bit selected by a mask byte, all in one cycle. Where a mask bit is set, the master always wins over that channel's own action, and the channel's own action is blocked even in cycles without a master match. Pins that are not driven by compare logic behave as ordinary general-purpose I/O. Their output enable comes from a direction register and their value from a port data register.

Software reaches every register through a simple single-cycle write and combinational read bus.

Top module: `occ_timer`

## Requirements
- R1: The counter resets to 0 and increments by exactly 1 on every clock edge, wrapping at 16 bits. It reads at address 14 and ignores writes.
- R2: The master mask register (address 10) and master data register (address 11) are 8 bits wide, reset to 0x00, and can be written and read back at any time.
- R3: Channel n matches in the cycle where the counter equals its compare register (address n, n = 0..7), provided bit n of the channel-select register (address 8) is 1. The resulting port change is visible only after the next clock edge.
- R4: The action register (address 9) holds the action of channel n in bits 2n+1:2n, encoded as 00 = leave, 01 = toggle, 10 = clear, 11 = set. The action is applied on a match of channel n only when that channel is an output compare and its mask bit is 0.
- R5: A match of channel 7, when channel 7 is an output compare, writes master data bit n to port bit n for every set mask bit n. Bits with a clear mask bit are not changed by the master.
- R6: When channel 7 and channel n match in the same cycle and mask bit n is set, port bit n takes the master data bit and channel n's own action is discarded.
- R7: A set mask bit blocks channel n's own action even in cycles when channel 7 does not match.
- R8: Pin n is driven from the compare latch, with its output enable high, when channel n is an output compare and either its action field is non-zero or its mask bit is 1. In this case the direction bit is ignored and is not modified.
- R9: A pin not driven from the compare latch takes its output enable from the direction register (address 12) and its value from the port data register (address 13). Address 15 reads the pin values.
- R10: After reset all configuration registers, the port latch, the pin values and the output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, commits on the rising edge |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| port_out | output | 8 | Timer pin values |
| port_oe | output | 8 | Timer pin output enables |

## Verification
Register writes take effect at the edge that ends the write cycle, so every readback and pin check is made at the falling edge after that edge. A compare match is recognised in the cycle the counter holds the compare value, and the port latch changes one edge later. The bench therefore polls the counter through the read bus at falling edges until it equals the target. It checks at that moment that the pin has not yet moved, then checks the new pin state one falling edge later. Output enables and pin values of non-compare pins follow the registers combinationally and are checked in the cycle after the write.

// File: rtl/occ_pkg.sv
package occ_pkg;

    localparam int N_CH    = 8;
    localparam int CNT_W   = 16;
    localparam int BUS_AW  = 4;
    localparam int BUS_DW  = 16;
    localparam int ACT_W   = 2;
    localparam int MASTER  = N_CH - 1;
    localparam int CH_IW   = $clog2(N_CH);
    localparam int ACTR_W  = N_CH * ACT_W;

    // register map: compare registers first, then the control block
    localparam logic [BUS_AW-1:0] A_OCSEL = BUS_AW'(N_CH);
    localparam logic [BUS_AW-1:0] A_ACT   = BUS_AW'(N_CH + 1);
    localparam logic [BUS_AW-1:0] A_MMASK = BUS_AW'(N_CH + 2);
    localparam logic [BUS_AW-1:0] A_MDATA = BUS_AW'(N_CH + 3);
    localparam logic [BUS_AW-1:0] A_DDR   = BUS_AW'(N_CH + 4);
    localparam logic [BUS_AW-1:0] A_PDATA = BUS_AW'(N_CH + 5);
    localparam logic [BUS_AW-1:0] A_CNT   = BUS_AW'(N_CH + 6);
    localparam logic [BUS_AW-1:0] A_PIN   = BUS_AW'(N_CH + 7);

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_act_e;

    typedef struct packed {
        logic [N_CH-1:0]   oc_sel;
        logic [ACTR_W-1:0] act;
        logic [N_CH-1:0]   mmask;
        logic [N_CH-1:0]   mdata;
        logic [N_CH-1:0]   ddr;
        logic [N_CH-1:0]   pdata;
    } occ_cfg_t;

    function automatic logic apply_act(input oc_act_e a, input logic cur);
        logic r;
        case (a)
            ACT_TOGGLE: r = ~cur;
            ACT_CLEAR:  r = 1'b0;
            ACT_SET:    r = 1'b1;
            default:    r = cur;
        endcase
        return r;
    endfunction

    function automatic oc_act_e act_of(input logic [ACTR_W-1:0] v, input int ch);
        return oc_act_e'(v[ch*ACT_W +: ACT_W]);
    endfunction

endpackage

// File: rtl/occ_counter.sv
module occ_counter
    import occ_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    // R1: one step per clock once out of reset
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/occ_regfile.sv
module occ_regfile
    import occ_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [BUS_AW-1:0]     addr,
    input  logic [BUS_DW-1:0]     wdata,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [N_CH-1:0]       pin_val,
    output occ_cfg_t              cfg,
    output logic [N_CH*CNT_W-1:0] cmp_flat,
    output logic [BUS_DW-1:0]     rdata
);

    logic [CNT_W-1:0] cmp_q [N_CH];
    occ_cfg_t         cfg_q;

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)
                    cmp_q[c] <= '0;
                else if (we && addr == BUS_AW'(c))
                    cmp_q[c] <= wdata[CNT_W-1:0];
            end
            assign cmp_flat[c*CNT_W +: CNT_W] = cmp_q[c];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (addr)
                A_OCSEL: cfg_q.oc_sel <= wdata[N_CH-1:0];
                A_ACT:   cfg_q.act    <= wdata[ACTR_W-1:0];
                A_MMASK: cfg_q.mmask  <= wdata[N_CH-1:0];
                A_MDATA: cfg_q.mdata  <= wdata[N_CH-1:0];
                A_DDR:   cfg_q.ddr    <= wdata[N_CH-1:0];
                A_PDATA: cfg_q.pdata  <= wdata[N_CH-1:0];
                default: ;
            endcase
        end
    end

    assign cfg = cfg_q;

    always_comb begin
        rdata = '0;
        if (addr < BUS_AW'(N_CH)) begin
            rdata = BUS_DW'(cmp_q[addr[CH_IW-1:0]]);
        end else begin
            case (addr)
                A_OCSEL: rdata = BUS_DW'(cfg_q.oc_sel);
                A_ACT:   rdata = BUS_DW'(cfg_q.act);
                A_MMASK: rdata = BUS_DW'(cfg_q.mmask);
                A_MDATA: rdata = BUS_DW'(cfg_q.mdata);
                A_DDR:   rdata = BUS_DW'(cfg_q.ddr);
                A_PDATA: rdata = BUS_DW'(cfg_q.pdata);
                A_CNT:   rdata = BUS_DW'(cnt);
                A_PIN:   rdata = BUS_DW'(pin_val);
                default: rdata = '0;
            endcase
        end
    end

    // R2: master mask and data leave reset cleared
    a_r2_master_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q.mmask == '0 && cfg_q.mdata == '0));

    // R1: the counter address is read-only
    a_r1_cnt_not_stored: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CNT) |=> cfg_q == $past(cfg_q));

endmodule

// File: rtl/occ_match.sv
module occ_match
    import occ_pkg::*;
(
    input  logic [CNT_W-1:0]      cnt,
    input  logic [N_CH*CNT_W-1:0] cmp_flat,
    input  logic [N_CH-1:0]       oc_sel,
    output logic [N_CH-1:0]       hit
);

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_eq
            assign hit[c] = oc_sel[c] && (cmp_flat[c*CNT_W +: CNT_W] == cnt);
        end
    endgenerate

endmodule

// File: rtl/occ_port.sv
module occ_port
    import occ_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  occ_cfg_t        cfg,
    input  logic [N_CH-1:0] hit,
    output logic [N_CH-1:0] port_out,
    output logic [N_CH-1:0] port_oe
);

    logic [N_CH-1:0] q_r;
    logic [N_CH-1:0] q_nxt;
    logic [N_CH-1:0] act_en;
    logic [N_CH-1:0] act_nz;
    logic [N_CH-1:0] drive;
    logic            master_hit;

    assign master_hit = hit[MASTER];
    assign act_en     = hit & ~cfg.mmask;

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_bit
            assign act_nz[c] = act_of(cfg.act, c) != ACT_NONE;

            always_comb begin
                q_nxt[c] = q_r[c];
                if (master_hit && cfg.mmask[c])
                    q_nxt[c] = cfg.mdata[c];
                else if (act_en[c])
                    q_nxt[c] = apply_act(act_of(cfg.act, c), q_r[c]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nxt;
    end

    assign drive    = cfg.oc_sel & (act_nz | cfg.mmask);
    assign port_oe  = drive | cfg.ddr;
    assign port_out = (drive & q_r) | (~drive & cfg.pdata);

    // R5: the master leaves unmasked bits alone when nothing else fires
    a_r5_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        (master_hit && act_en == '0) |=> ((q_r ^ $past(q_r)) & ~$past(cfg.mmask)) == '0);

    // R6: masked bits take the master data on a master match
    a_r6_master_wins: assert property (@(posedge clk) disable iff (rst)
        master_hit |=> ((q_r ^ $past(cfg.mdata)) & $past(cfg.mmask)) == '0);

    // R7: without a master match, masked bits never change
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        !master_hit |=> ((q_r ^ $past(q_r)) & $past(cfg.mmask)) == '0);

    // R9: with no compare channel selected the pins are plain I/O
    a_r9_plain_io: assert property (@(posedge clk) disable iff (rst)
        (cfg.oc_sel == '0) |-> (port_oe == cfg.ddr && port_out == cfg.pdata));

endmodule

// File: rtl/occ_timer.sv
module occ_timer
    import occ_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic [N_CH-1:0]   port_out,
    output logic [N_CH-1:0]   port_oe
);

    logic [CNT_W-1:0]      cnt;
    logic [N_CH*CNT_W-1:0] cmp_flat;
    logic [N_CH-1:0]       hit;
    occ_cfg_t              cfg;

    occ_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .cnt (cnt)
    );

    occ_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .pin_val  (port_out),
        .cfg      (cfg),
        .cmp_flat (cmp_flat),
        .rdata    (bus_rdata)
    );

    occ_match u_match (
        .cnt      (cnt),
        .cmp_flat (cmp_flat),
        .oc_sel   (cfg.oc_sel),
        .hit      (hit)
    );

    occ_port u_port (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .hit      (hit),
        .port_out (port_out),
        .port_oe  (port_oe)
    );

endmodule

// File: tb/occ_timer_tb.sv
module occ_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    localparam logic [3:0] A_OCSEL = 4'd8,  A_ACT = 4'd9,  A_MMASK = 4'd10,
                           A_MDATA = 4'd11, A_DDR = 4'd12, A_PDATA = 4'd13,
                           A_CNT   = 4'd14, A_PIN = 4'd15;

    typedef struct packed {
        logic [7:0]  init;
        logic [7:0]  sel;
        logic [15:0] act;
        logic [7:0]  mask;
        logic [7:0]  mdat;
        logic [7:0]  exp_out;
        logic [7:0]  exp_oe;
    } vec_t;

    // R4/R5/R6/R7/R8 vectors: start latch, select, actions, mask, data -> pins, enables
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'hFF, 16'h5555, 8'h00, 8'hFF, 8'hFF, 8'hFF},
        '{8'hFF, 8'hFF, 16'hAAAA, 8'h0F, 8'h05, 8'h05, 8'hFF},
        '{8'h00, 8'hFF, 16'hFFFF, 8'hF0, 8'h30, 8'h3F, 8'hFF},
        '{8'h00, 8'h0F, 16'h00FF, 8'hFF, 8'hFF, 8'h00, 8'h0F},
        '{8'h00, 8'hFF, 16'h0000, 8'h81, 8'h81, 8'h81, 8'h81},
        '{8'h3C, 8'hFF, 16'hC06D, 8'h00, 8'h00, 8'h83, 8'h8F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  port_out;
    logic [7:0]  port_oe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    occ_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .port_out  (port_out),
        .port_oe   (port_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // returns at the falling edge of the cycle in which the counter equals t
    task automatic wait_cnt(input logic [15:0] t);
        logic [15:0] v;
        int guard = 0;
        do begin
            @(negedge clk);
            rd(A_CNT, v);
            guard++;
        end while (v != t && guard < 70000);
    endtask

    task automatic future(input int ahead, output logic [15:0] t);
        logic [15:0] v;
        @(negedge clk);
        rd(A_CNT, v);
        t = v + 16'(ahead);
    endtask

    task automatic load_latch(input logic [7:0] val);
        logic [15:0] t;
        wr(A_OCSEL, 16'h0080);
        wr(A_ACT,   16'h0000);
        wr(A_MMASK, 16'h00FF);
        wr(A_MDATA, {8'h00, val});
        future(20, t);
        wr(4'd7, t);
        wait_cnt(t);
        @(negedge clk);
    endtask

    task automatic run_vec(input int i);
        logic [15:0] t;
        vec_t v;
        v = VECS[i];
        load_latch(v.init);
        wr(A_OCSEL, {8'h00, v.sel});
        wr(A_ACT,   v.act);
        wr(A_MMASK, {8'h00, v.mask});
        wr(A_MDATA, {8'h00, v.mdat});
        future(40, t);
        for (int c = 0; c < 8; c++) wr(4'(c), t);
        wait_cnt(t);
        @(negedge clk);
        chk($sformatf("R4/R5/R6/R7 vector %0d pins", i), {8'h00, port_out}, {8'h00, v.exp_out});
        chk($sformatf("R8 vector %0d enables", i), {8'h00, port_oe}, {8'h00, v.exp_oe});
    endtask

    initial begin
        logic [15:0] a, b, t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 pins after reset", {8'h00, port_out}, 16'h0000);
        chk("R10 enables after reset", {8'h00, port_oe}, 16'h0000);
        rd(A_MMASK, a); chk("R2 mask reset", a, 16'h0000);
        rd(A_MDATA, a); chk("R2 data reset", a, 16'h0000);

        // R1 counter steps by one per clock and ignores writes
        @(negedge clk); rd(A_CNT, a);
        @(negedge clk); rd(A_CNT, b);
        chk("R1 counter step", b, a + 16'd1);
        wr(A_CNT, 16'h1234);
        rd(A_CNT, a);
        @(negedge clk); rd(A_CNT, b);
        chk("R1 counter ignores write", b, a + 16'd1);

        // R2 read/write any time
        wr(A_MMASK, 16'h005A); rd(A_MMASK, a); chk("R2 mask readback", a, 16'h005A);
        wr(A_MDATA, 16'h00C3); rd(A_MDATA, a); chk("R2 data readback", a, 16'h00C3);

        // R9 plain I/O, then R8 compare drive ignoring direction
        wr(A_MMASK, 16'h00FF);
        wr(A_DDR,   16'h0055);
        wr(A_PDATA, 16'h0033);
        chk("R9 plain enables", {8'h00, port_oe}, 16'h0055);
        chk("R9 plain values", {8'h00, port_out}, 16'h0033);
        rd(A_PIN, a); chk("R9 pin readback", a, 16'h0033);
        wr(A_OCSEL, 16'h000F);
        chk("R8 mask forces enable", {8'h00, port_oe}, 16'h005F);
        chk("R8 compare pins from latch", {8'h00, port_out}, 16'h0030);
        rd(A_DDR, a); chk("R8 direction unmodified", a, 16'h0055);
        wr(A_DDR, 16'h0000); wr(A_PDATA, 16'h0000);
        wr(A_MMASK, 16'h0000); wr(A_MDATA, 16'h0000);

        // R3 timing: toggle on channel 0 appears one edge after the match
        wr(A_OCSEL, 16'h0001);
        wr(A_ACT,   16'h0001);
        future(30, t);
        wr(4'd0, t);
        wait_cnt(t);
        chk("R3 no change during match cycle", {8'h00, port_out}, 16'h0000);
        @(negedge clk);
        chk("R3 toggle after edge", {8'h00, port_out}, 16'h0001);
        @(negedge clk);
        chk("R3 no repeat after match", {8'h00, port_out}, 16'h0001);
        // R3 unselected channel does not act
        wr(A_OCSEL, 16'h0000);
        wr(A_ACT,   16'h0003);
        future(30, t);
        wr(4'd0, t);
        wait_cnt(t);
        @(negedge clk);
        wr(A_OCSEL, 16'h0001);
        chk("R3 unselected channel holds latch", {8'h00, port_out}, 16'h0001);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R7 mask blocks the own action with no master match
        load_latch(8'h00);
        wr(A_OCSEL, 16'h0002);
        wr(A_ACT,   16'h000C);
        wr(A_MMASK, 16'h0002);
        future(30, t);
        wr(4'd1, t);
        wait_cnt(t);
        @(negedge clk);
        chk("R7 masked set blocked", {8'h00, port_out}, 16'h0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule